// File: doc/BRIEF.md
# Host Bridge Configuration Space with Upper-Memory Shadow Routing

This block is the configuration register space of a host-to-PCI bridge. Software reaches it through a byte-wide configuration port made of a function number, a register offset, write data, a write strobe and a read-data return. The port is combinational on reads and commits writes on the clock edge. After reset the space holds the bridge's identification and class bytes. Every other byte starts at zero, and each offset can be written subject to a mask that belongs to that offset.

Three of the registers steer memory decoding, and the block turns their contents straight into routing attributes. One register enables eight windows in the option-ROM area, one bit per window. A second register holds a global shadow-read enable and a global write-protect bit. From these the block drives a 2-bit read route and a 2-bit write route for each of eight windows:

- seven option-ROM windows: one 32 KB window at C0000 and six 16 KB windows from C8000 up to DFFFF;
- the 128 KB system BIOS window at E0000.

A third register drives the external L2 cache enable and its write-back/write-through selection. A memory decoder downstream uses these attributes directly.

Top module: `hbc_top`

## Requirements
- R1: After reset a function-0 read returns 0x60, 0x10, 0x81, 0x88 at offsets 0x00 to 0x03, 0x01 at offset 0x08, 0x06 at offset 0x0B, and 0x00 at every other offset.
- R2: Writes to offsets 0x00 to 0x03 leave those bytes unchanged.
- R3: A function-0 write to any offset from 0x04 up stores the data ANDed with a per-offset mask. The mask is 0xFE at 0x54, 0x3F at 0x60, 0x0F at 0x61, and 0xFF at every other writable offset.
- R4: Bit 1 of offset 0x54 enables window 0 (C0000–C7FFF). Bits 2 to 7 enable windows 1 to 6 (16 KB each, ascending from C8000). Window w drives route bits [2w+1:2w] of each route output.
- R5: The read route of an enabled window is 01 (internal RAM) when bit 7 of offset 0x55 is 1, and 00 (external bus) when it is 0.
- R6: The write route of an enabled window is 10 (blocked) when bit 6 of offset 0x55 is 1, and 01 (internal RAM) when it is 0.
- R7: A window whose enable bit is 0 has both its read route and its write route equal to 00 (external bus).
- R8: Window 7 (E0000–FFFFF) is always treated as enabled, so its routes follow offset 0x55 alone, whatever offset 0x54 holds.
- R9: `l2_enable` equals bit 7 of offset 0x50, and `l2_writeback` equals bit 6 of offset 0x50.
- R10: Route and cache outputs take their new values in the cycle that follows the clock edge on which the write commits.
- R11: An access with a nonzero function number stores nothing and reads back 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_func | input | 3 | Configuration function number; only 0 is implemented |
| cfg_addr | input | 8 | Register offset |
| cfg_we | input | 1 | Write strobe, committed on the rising edge |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data for cfg_func/cfg_addr (combinational) |
| l2_enable | output | 1 | External L2 cache enable |
| l2_writeback | output | 1 | L2 policy: 1 write-back, 0 write-through |
| win_rd_route | output | 16 | Per-window read route, 2 bits per window |
| win_wr_route | output | 16 | Per-window write route, 2 bits per window |

## Verification
The hardest situation to reach is a window whose enable bit and the global policy bits change on different writes. A mistake then shows only for particular combinations, for example a disabled window that leaks the write-protect code, or a BIOS window that wrongly depends on an enable bit. The stimulus aims most of a long pseudo-random write stream at the three steering offsets, with arbitrary data and occasional nonzero function numbers. Every combination of enable pattern and policy then occurs many times, and a behavioural model checks all eight windows after each write.

// File: rtl/hbc_pkg.sv
package hbc_pkg;

    // Offsets whose position is decoded by the routing logic
    localparam logic [7:0] OFF_CACHE  = 8'h50;
    localparam logic [7:0] OFF_SH_EN  = 8'h54;
    localparam logic [7:0] OFF_SH_POL = 8'h55;
    localparam logic [7:0] OFF_MSK_A  = 8'h60;
    localparam logic [7:0] OFF_MSK_B  = 8'h61;

    // Last read-only identification offset
    localparam logic [7:0] LAST_RO    = 8'h03;

    typedef enum logic [1:0] {
        RD_EXT = 2'b00,
        RD_INT = 2'b01
    } rd_route_e;

    typedef enum logic [1:0] {
        WR_EXT   = 2'b00,
        WR_INT   = 2'b01,
        WR_BLOCK = 2'b10
    } wr_route_e;

    typedef struct packed {
        logic rd_internal;
        logic wr_protect;
    } shadow_pol_t;

    typedef struct packed {
        logic enable;
        logic writeback;
    } l2_ctl_t;

    function automatic logic [7:0] store_mask(input logic [7:0] off);
        case (off)
            OFF_SH_EN: store_mask = 8'hFE;
            OFF_MSK_A: store_mask = 8'h3F;
            OFF_MSK_B: store_mask = 8'h0F;
            default:   store_mask = 8'hFF;
        endcase
    endfunction

    function automatic logic [7:0] reset_value(input logic [7:0] off);
        case (off)
            8'h00:   reset_value = 8'h60;
            8'h01:   reset_value = 8'h10;
            8'h02:   reset_value = 8'h81;
            8'h03:   reset_value = 8'h88;
            8'h08:   reset_value = 8'h01;
            8'h0B:   reset_value = 8'h06;
            default: reset_value = 8'h00;
        endcase
    endfunction

    function automatic logic is_writable(input logic [7:0] off);
        is_writable = (off > LAST_RO);
    endfunction

endpackage

// File: rtl/hbc_regfile.sv
module hbc_regfile
    import hbc_pkg::*;
#(
    parameter int FUNC_W      = 3,
    parameter int NUM_OPT_WIN = 7
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [FUNC_W-1:0]      cfg_func,
    input  logic [7:0]             cfg_addr,
    input  logic                   cfg_we,
    input  logic [7:0]             cfg_wdata,
    output logic [7:0]             cfg_rdata,
    output logic [NUM_OPT_WIN-1:0] opt_en,
    output shadow_pol_t            sh_pol,
    output l2_ctl_t                l2_ctl
);
    localparam int DEPTH = 256;

    logic [7:0] regs [DEPTH];
    logic       func_hit;
    logic       commit;

    assign func_hit = (cfg_func == '0);
    assign commit   = cfg_we && func_hit && is_writable(cfg_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                regs[i] <= reset_value(8'(i));
            end
        end else if (commit) begin
            regs[cfg_addr] <= cfg_wdata & store_mask(cfg_addr);
        end
    end

    always_comb begin
        cfg_rdata = func_hit ? regs[cfg_addr] : 8'hFF;
    end

    assign opt_en             = regs[OFF_SH_EN][NUM_OPT_WIN:1];
    assign sh_pol.rd_internal = regs[OFF_SH_POL][7];
    assign sh_pol.wr_protect  = regs[OFF_SH_POL][6];
    assign l2_ctl.enable      = regs[OFF_CACHE][7];
    assign l2_ctl.writeback   = regs[OFF_CACHE][6];

endmodule

// File: rtl/hbc_route.sv
module hbc_route
    import hbc_pkg::*;
#(
    parameter int NUM_OPT_WIN = 7
) (
    input  logic [NUM_OPT_WIN-1:0]   opt_en,
    input  shadow_pol_t              sh_pol,
    output logic [2*NUM_OPT_WIN+1:0] win_rd_route,
    output logic [2*NUM_OPT_WIN+1:0] win_wr_route
);
    localparam int NWIN = NUM_OPT_WIN + 1;

    rd_route_e on_rd;
    wr_route_e on_wr;

    always_comb begin
        on_rd = sh_pol.rd_internal ? RD_INT : RD_EXT;
        on_wr = sh_pol.wr_protect  ? WR_BLOCK : WR_INT;
    end

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        logic win_on;
        if (w == NWIN - 1) begin : g_bios
            assign win_on = 1'b1;
        end else begin : g_opt
            assign win_on = opt_en[w];
        end
        assign win_rd_route[2*w +: 2] = win_on ? on_rd : RD_EXT;
        assign win_wr_route[2*w +: 2] = win_on ? on_wr : WR_EXT;
    end

endmodule

// File: rtl/hbc_top.sv
module hbc_top
    import hbc_pkg::*;
#(
    parameter int FUNC_W      = 3,
    parameter int NUM_OPT_WIN = 7
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [FUNC_W-1:0]      cfg_func,
    input  logic [7:0]             cfg_addr,
    input  logic                   cfg_we,
    input  logic [7:0]             cfg_wdata,
    output logic [7:0]             cfg_rdata,
    output logic                   l2_enable,
    output logic                   l2_writeback,
    output logic [2*NUM_OPT_WIN+1:0] win_rd_route,
    output logic [2*NUM_OPT_WIN+1:0] win_wr_route
);
    logic [NUM_OPT_WIN-1:0] opt_en;
    shadow_pol_t            sh_pol;
    l2_ctl_t                l2_ctl;

    hbc_regfile #(
        .FUNC_W      (FUNC_W),
        .NUM_OPT_WIN (NUM_OPT_WIN)
    ) u_regfile (
        .clk       (clk),
        .rst       (rst),
        .cfg_func  (cfg_func),
        .cfg_addr  (cfg_addr),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .opt_en    (opt_en),
        .sh_pol    (sh_pol),
        .l2_ctl    (l2_ctl)
    );

    hbc_route #(
        .NUM_OPT_WIN (NUM_OPT_WIN)
    ) u_route (
        .opt_en       (opt_en),
        .sh_pol       (sh_pol),
        .win_rd_route (win_rd_route),
        .win_wr_route (win_wr_route)
    );

    assign l2_enable    = l2_ctl.enable;
    assign l2_writeback = l2_ctl.writeback;

endmodule

// File: rtl/hbc_check.sv
module hbc_check #(
    parameter int FUNC_W      = 3,
    parameter int NUM_OPT_WIN = 7
) (
    input logic                     clk,
    input logic                     rst,
    input logic [FUNC_W-1:0]        cfg_func,
    input logic [7:0]               cfg_addr,
    input logic                     cfg_we,
    input logic [7:0]               cfg_wdata,
    input logic [7:0]               cfg_rdata,
    input logic                     l2_enable,
    input logic                     l2_writeback,
    input logic [2*NUM_OPT_WIN+1:0] win_rd_route,
    input logic [2*NUM_OPT_WIN+1:0] win_wr_route,
    input logic [NUM_OPT_WIN-1:0]   opt_en
);
    localparam int TOP = 2 * NUM_OPT_WIN;

    logic f0;
    assign f0 = (cfg_func == '0);

    AST_ID_RO: assert property (@(posedge clk) disable iff (rst)
        (f0 && cfg_addr == 8'h00) |-> cfg_rdata == 8'h60); // R2

    AST_OTHER_FUNC: assert property (@(posedge clk) disable iff (rst)
        (!f0) |-> cfg_rdata == 8'hFF); // R11

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (f0 && cfg_addr == 8'h54) |-> cfg_rdata[0] == 1'b0); // R3

    AST_MASK_61: assert property (@(posedge clk) disable iff (rst)
        (f0 && cfg_addr == 8'h61) |-> cfg_rdata[7:4] == 4'h0); // R3

    AST_EN_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && f0 && cfg_addr == 8'h54) |=> opt_en == $past(cfg_wdata[NUM_OPT_WIN:1])); // R4

    AST_L2_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && f0 && cfg_addr == 8'h50) |=>
            (l2_enable == $past(cfg_wdata[7]) && l2_writeback == $past(cfg_wdata[6]))); // R9

    AST_BIOS_WP: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && f0 && cfg_addr == 8'h55) |=>
            win_wr_route[TOP +: 2] == ($past(cfg_wdata[6]) ? 2'b10 : 2'b01)); // R8

    AST_DIS_EXT: assert property (@(posedge clk) disable iff (rst)
        (!opt_en[0]) |-> (win_rd_route[1:0] == 2'b00 && win_wr_route[1:0] == 2'b00)); // R7

endmodule

bind hbc_top hbc_check #(
    .FUNC_W      (FUNC_W),
    .NUM_OPT_WIN (NUM_OPT_WIN)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_func     (cfg_func),
    .cfg_addr     (cfg_addr),
    .cfg_we       (cfg_we),
    .cfg_wdata    (cfg_wdata),
    .cfg_rdata    (cfg_rdata),
    .l2_enable    (l2_enable),
    .l2_writeback (l2_writeback),
    .win_rd_route (win_rd_route),
    .win_wr_route (win_wr_route),
    .opt_en       (opt_en)
);

// File: tb/hbc_top_bench.sv
module hbc_top_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  cfg_func = 3'd0;
    logic [7:0]  cfg_addr = 8'd0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_wdata = 8'd0;
    logic [7:0]  cfg_rdata;
    logic        l2_enable, l2_writeback;
    logic [15:0] win_rd_route, win_wr_route;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit compare_on = 1'b0;
    int model [256];

    always #10 clk = ~clk;

    hbc_top u_hbc_top (
        .clk(clk), .rst(rst), .cfg_func(cfg_func), .cfg_addr(cfg_addr),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .l2_enable(l2_enable), .l2_writeback(l2_writeback),
        .win_rd_route(win_rd_route), .win_wr_route(win_wr_route)
    );

    function automatic int init_byte(int a);
        case (a)
            0: return 'h60;  1: return 'h10;  2: return 'h81;  3: return 'h88;
            8: return 'h01;  11: return 'h06;
            default: return 0;
        endcase
    endfunction

    function automatic int keep_bits(int a);
        if (a == 'h54) return 'hFE;
        if (a == 'h60) return 'h3F;
        if (a == 'h61) return 'h0F;
        return 'hFF;
    endfunction

    task automatic check(string tag, int actual, int expected);
        checks++;
        if (actual != expected) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, actual, expected);
        end
    endtask

    // Behavioural model: updated on the same edge the design commits (R10)
    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            for (int a = 0; a < 256; a++) model[a] = init_byte(a);
        end else if (cfg_we && cfg_func == 0 && cfg_addr > 3) begin
            model[cfg_addr] = cfg_wdata & keep_bits(cfg_addr);
        end
    end

    // Compare all outputs mid-cycle
    always @(negedge clk) begin
        if (compare_on && !rst) begin
            int a;
            int exp_rd;
            a = cfg_addr;
            if (cfg_func != 0)  check("R11 read", cfg_rdata, 'hFF);
            else if (a < 4)     check("R1 R2 id read", cfg_rdata, model[a]);
            else if (keep_bits(a) != 'hFF) check("R3 masked read", cfg_rdata, model[a]);
            else                check("R1 R3 read", cfg_rdata, model[a]);
            check("R9 R10 l2_enable", l2_enable, (model['h50] >> 7) & 1);
            check("R9 l2_writeback", l2_writeback, (model['h50] >> 6) & 1);
            for (int w = 0; w < 8; w++) begin
                bit on;
                int exp_wr;
                on = (w == 7) ? 1'b1 : ((model['h54] >> (w + 1)) & 1) != 0;
                exp_rd = on ? ((model['h55] >> 7) & 1) : 0;
                exp_wr = on ? ((((model['h55] >> 6) & 1) != 0) ? 2 : 1) : 0;
                if (w == 7) begin
                    check($sformatf("R8 rd win%0d", w), win_rd_route[2*w +: 2], exp_rd);
                    check($sformatf("R8 wr win%0d", w), win_wr_route[2*w +: 2], exp_wr);
                end else if (on) begin
                    check($sformatf("R4 R5 rd win%0d", w), win_rd_route[2*w +: 2], exp_rd);
                    check($sformatf("R4 R6 wr win%0d", w), win_wr_route[2*w +: 2], exp_wr);
                end else begin
                    check($sformatf("R7 rd win%0d", w), win_rd_route[2*w +: 2], exp_rd);
                    check($sformatf("R7 wr win%0d", w), win_wr_route[2*w +: 2], exp_wr);
                end
            end
        end
    end

    task automatic drive(input int f, input int a, input bit we, input int d);
        @(posedge clk);
        #2;
        cfg_func  = 3'(f);
        cfg_addr  = 8'(a);
        cfg_we    = we;
        cfg_wdata = 8'(d);
    endtask

    initial begin : watchdog
        wait (cycles > 150000);
        failures++;
        $display("FAIL watchdog actual=%0d expected<150000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int a;
        int d;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        compare_on = 1'b1;
        // R1: reset contents over the whole space
        for (int i = 0; i < 256; i++) drive(0, i, 1'b0, 0);
        // R2: identification bytes do not take writes
        for (int i = 0; i < 4; i++) drive(0, i, 1'b1, 'h5A);
        for (int i = 0; i < 4; i++) drive(0, i, 1'b0, 0);
        // R3: masks at the masked offsets with all-ones data
        drive(0, 'h54, 1'b1, 'hFF); drive(0, 'h60, 1'b1, 'hFF);
        drive(0, 'h61, 1'b1, 'hFF); drive(0, 'h40, 1'b1, 'hFF);
        drive(0, 'h54, 1'b0, 0); drive(0, 'h60, 1'b0, 0); drive(0, 'h61, 1'b0, 0);
        // R8: BIOS window follows policy with every option window off
        drive(0, 'h54, 1'b1, 'h00); drive(0, 'h55, 1'b1, 'hC0);
        drive(0, 'h55, 1'b1, 'h80); drive(0, 'h55, 1'b1, 'h40);
        // R4: walk a single enable bit through every window
        for (int b = 1; b < 8; b++) drive(0, 'h54, 1'b1, 1 << b);
        // R11: other functions store nothing
        drive(1, 'h54, 1'b1, 'hFF); drive(5, 'h50, 1'b1, 'hFF);
        drive(0, 'h54, 1'b0, 0); drive(0, 'h50, 1'b0, 0);
        // R9: cache control
        drive(0, 'h50, 1'b1, 'h80); drive(0, 'h50, 1'b1, 'h40); drive(0, 'h50, 1'b1, 'hC0);
        // Mixed stream focused on the steering offsets
        for (int n = 0; n < 4000; n++) begin
            case ($urandom % 6)
                0: a = 'h50;
                1, 2: a = 'h54;
                3: a = 'h55;
                4: a = 'h60 + ($urandom % 2);
                default: a = $urandom % 256;
            endcase
            d = $urandom % 256;
            drive(($urandom % 8 == 0) ? 1 + ($urandom % 7) : 0, a, ($urandom % 4) != 0, d);
        end
        drive(0, 0, 1'b0, 0);
        @(posedge clk);
        @(negedge clk);
        compare_on = 1'b0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule